// File: doc/BRIEF.md
# LCD Row Scan and Frame Polarity Generator

This block paces the row scan of a multiplexed dot-matrix LCD. It divides a reference tick down to a line period. Once per line it emits an active-high line pulse. The falling edge of that pulse moves the selection to the next row of the matrix. After every full pass over the rows, the frame polarity signal inverts, and row scanning starts again from the first row.

Alongside the timing, the block produces drive-level codes for an external analog stage. There are four codes: selected row, unselected rows, lit columns and dark columns. Each code is an integer N from 0 to 9. The analog stage turns N into the low rail plus N ninths of the span between the rails.

The four codes take one set of values in one polarity. In the other polarity each code becomes 9 minus its first value. Every cell therefore sees equal and opposite drive over two frames, so no net DC builds up across it. When `enable` is low, the scan state returns to its reset values and no row is selected.

Top module: `row_scan_gen`

## Requirements
- R1: While `enable` is high, exactly one bit of `row_sel` is set, and it is bit `row_idx`. While `enable` is low, `row_sel` is all zeros.
- R2: Counted from reset or from the cycle where `enable` returns high, `line_pulse` first rises after `TICKS_PER_LINE` ticks. It then repeats every `TICKS_PER_LINE` ticks and stays high for `PULSE_TICKS` ticks each time.
- R3: On the cycle in which `line_pulse` falls, `row_idx` advances by one. It wraps from `ROWS-1` to 0.
- R4: `frame_pol` inverts only on the falling edge of every `ROWS`-th line pulse, which is the edge at which `row_idx` wraps to 0.
- R5: Row codes are 4-bit binary N. With `frame_pol`=0, the selected row uses 9 and unselected rows use 1. With `frame_pol`=1, the selected row uses 0 and unselected rows use 8.
- R6: Column codes are 4-bit binary N. With `frame_pol`=0, lit columns use 0 and dark columns use 2. With `frame_pol`=1, lit columns use 9 and dark columns use 7.
- R7: After a synchronous reset, `frame_pol` is 0, `row_idx` is 0 and `line_pulse` is low.
- R8: On cycles where `tick` is low, the line timing, the row index and the polarity all hold their values.
- R9: While `enable` is low, the timing state is held at its reset values: no pulse, row 0, polarity 0. Raising `enable` restarts the scan exactly as after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick qualifier, one count per high cycle |
| enable | input | 1 | Scan run control |
| line_pulse | output | 1 | Active-high line pulse |
| frame_pol | output | 1 | Frame polarity |
| row_idx | output | $clog2(ROWS) | Index of the selected row |
| row_sel | output | ROWS | One-hot selected-row vector |
| row_on_lvl | output | 4 | Level code for the selected row |
| row_off_lvl | output | 4 | Level code for unselected rows |
| col_on_lvl | output | 4 | Level code for lit columns |
| col_off_lvl | output | 4 | Level code for dark columns |

## Verification
The hardest event to reach from the ports is the polarity inversion. It needs a whole frame of line pulses, and it must land exactly on the row wrap. The bench therefore builds the block with an eight-tick line. It runs continuous ticks past two inversions and then continues with sparse ticks. A tick counter in the bench gives the expected pulse, row, polarity and code values for every cycle. Disabling the block and resetting it mid-frame are also checked against a restart from zero.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    localparam int LVL_W = 4;
    localparam logic [LVL_W-1:0] LVL_SPAN = 4'd9;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } polarity_e;

    typedef struct packed {
        lvl_t row_on;
        lvl_t row_off;
        lvl_t col_on;
        lvl_t col_off;
    } drive_set_t;

    function automatic drive_set_t positive_set();
        drive_set_t s;
        s.row_on  = 4'd9;
        s.row_off = 4'd1;
        s.col_on  = 4'd0;
        s.col_off = 4'd2;
        return s;
    endfunction

    function automatic lvl_t mirror_lvl(lvl_t l);
        return LVL_SPAN - l;
    endfunction

    function automatic drive_set_t set_for(polarity_e p);
        drive_set_t b;
        drive_set_t m;
        b = positive_set();
        m.row_on  = mirror_lvl(b.row_on);
        m.row_off = mirror_lvl(b.row_off);
        m.col_on  = mirror_lvl(b.col_on);
        m.col_off = mirror_lvl(b.col_off);
        return (p == POL_NEG) ? m : b;
    endfunction

endpackage

// File: rtl/line_timer.sv
module line_timer #(
    parameter int TICKS_PER_LINE = 244,
    parameter int PULSE_TICKS    = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic line_pulse,
    output logic pulse_end
);
    localparam int CNT_W = (TICKS_PER_LINE > 1) ? $clog2(TICKS_PER_LINE) : 1;
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(TICKS_PER_LINE - 1);
    localparam logic [CNT_W-1:0] PW_LAST = CNT_W'(PULSE_TICKS - 1);

    logic [CNT_W-1:0] tcnt;

    assign pulse_end = run && tick && line_pulse && (tcnt == PW_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt       <= '0;
            line_pulse <= 1'b0;
        end else if (tick) begin
            if (tcnt == LAST) begin
                tcnt       <= '0;
                line_pulse <= 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
            if (pulse_end) begin
                line_pulse <= 1'b0;
            end
        end
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        tcnt <= LAST);

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst) && !$past(tick)) |->
            ($stable(tcnt) && $stable(line_pulse)));

    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!line_pulse && tcnt == '0));

endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
    import row_scan_pkg::*;
#(
    parameter int ROWS = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      run,
    input  logic                      advance,
    output logic [$clog2(ROWS)-1:0]   row_idx,
    output polarity_e                 frame,
    output logic [ROWS-1:0]           row_sel
);
    localparam int ROW_W = $clog2(ROWS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            row_idx <= '0;
            frame   <= POL_POS;
        end else if (advance) begin
            if (row_idx == ROW_LAST) begin
                row_idx <= '0;
                frame   <= (frame == POL_POS) ? POL_NEG : POL_POS;
            end else begin
                row_idx <= row_idx + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_row_dec
        assign row_sel[g] = run && (row_idx == ROW_W'(g));
    end

    assert_one_row_R1: assert property (@(posedge clk) disable iff (rst)
        run |-> ($countones(row_sel) == 1));

    assert_no_row_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !run |-> (row_sel == '0));

    assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst) && $past(advance)) |->
            (row_idx == (($past(row_idx) == ROW_LAST) ? '0 : $past(row_idx) + 1'b1)));

    assert_frame_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst) && (frame != $past(frame))) |->
            (row_idx == '0 && $past(row_idx) == ROW_LAST));

endmodule

// File: rtl/level_mapper.sv
module level_mapper
    import row_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  polarity_e  frame,
    output drive_set_t lv
);
    assign lv = set_for(frame);

    assert_row_mirror_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame != $past(frame)) |->
            (lv.row_on == LVL_SPAN - $past(lv.row_on) &&
             lv.row_off == LVL_SPAN - $past(lv.row_off)));

    assert_col_mirror_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame != $past(frame)) |->
            (lv.col_on == LVL_SPAN - $past(lv.col_on) &&
             lv.col_off == LVL_SPAN - $past(lv.col_off)));

    assert_lvl_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (lv.row_on <= LVL_SPAN && lv.row_off <= LVL_SPAN &&
         lv.col_on <= LVL_SPAN && lv.col_off <= LVL_SPAN));

endmodule

// File: rtl/row_scan_gen.sv
module row_scan_gen
    import row_scan_pkg::*;
#(
    parameter int ROWS           = 64,
    parameter int TICKS_PER_LINE = 244,
    parameter int PULSE_TICKS    = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    enable,
    output logic                    line_pulse,
    output logic                    frame_pol,
    output logic [$clog2(ROWS)-1:0] row_idx,
    output logic [ROWS-1:0]         row_sel,
    output logic [3:0]              row_on_lvl,
    output logic [3:0]              row_off_lvl,
    output logic [3:0]              col_on_lvl,
    output logic [3:0]              col_off_lvl
);
    logic       pulse_end;
    polarity_e  frame;
    drive_set_t lv;

    line_timer #(
        .TICKS_PER_LINE(TICKS_PER_LINE),
        .PULSE_TICKS   (PULSE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (enable),
        .tick      (tick),
        .line_pulse(line_pulse),
        .pulse_end (pulse_end)
    );

    row_sequencer #(
        .ROWS(ROWS)
    ) u_rows (
        .clk    (clk),
        .rst    (rst),
        .run    (enable),
        .advance(pulse_end),
        .row_idx(row_idx),
        .frame  (frame),
        .row_sel(row_sel)
    );

    level_mapper u_levels (
        .clk  (clk),
        .rst  (rst),
        .frame(frame),
        .lv   (lv)
    );

    assign frame_pol   = (frame == POL_NEG);
    assign row_on_lvl  = lv.row_on;
    assign row_off_lvl = lv.row_off;
    assign col_on_lvl  = lv.col_on;
    assign col_off_lvl = lv.col_off;

    assert_frame_only_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(rst) && $changed(frame_pol)) |->
            $fell(line_pulse));

    assert_reset_state_R7: assert property (@(posedge clk)
        $past(rst) |-> (!line_pulse && !frame_pol && row_idx == '0));

endmodule

// File: tb/test_row_scan_gen.sv
module test_row_scan_gen;
    localparam int ROWS = 64;
    localparam int L    = 8;
    localparam int PW   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic enable = 1'b0;
    logic line_pulse, frame_pol;
    logic [5:0] row_idx;
    logic [ROWS-1:0] row_sel;
    logic [3:0] row_on_lvl, row_off_lvl, col_on_lvl, col_off_lvl;

    int n = 0;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    row_scan_gen #(.ROWS(ROWS), .TICKS_PER_LINE(L), .PULSE_TICKS(PW)) i_row_scan_gen (
        .clk(clk), .rst(rst), .tick(tick), .enable(enable),
        .line_pulse(line_pulse), .frame_pol(frame_pol), .row_idx(row_idx),
        .row_sel(row_sel), .row_on_lvl(row_on_lvl), .row_off_lvl(row_off_lvl),
        .col_on_lvl(col_on_lvl), .col_off_lvl(col_off_lvl)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s n=%0d actual=%h expected=%h", tag, n, act, exp);
        end
    endtask

    task automatic check_all();
        int falls;
        bit exp_pulse;
        logic [5:0] exp_row;
        bit exp_frame;
        logic [ROWS-1:0] exp_sel;
        if (!enable) begin
            chk(row_sel == '0, "R1 idle select", row_sel, 0);
            chk(line_pulse == 1'b0, "R9 idle pulse", line_pulse, 0);
            chk(row_idx == 6'd0 && frame_pol == 1'b0, "R9 idle state",
                {frame_pol, row_idx}, 0);
        end else begin
            exp_pulse = (n >= L) && ((n % L) < PW);
            falls = (n >= L + PW) ? ((n - PW) / L) : 0;
            exp_row = 6'(falls % ROWS);
            exp_frame = ((falls / ROWS) % 2) == 1;
            exp_sel = '0;
            exp_sel[exp_row] = 1'b1;
            chk(line_pulse == exp_pulse, "R2 pulse", line_pulse, exp_pulse);
            chk(row_idx == exp_row, "R3 row index", row_idx, exp_row);
            chk(frame_pol == exp_frame, "R4 polarity", frame_pol, exp_frame);
            chk(row_sel == exp_sel, "R1 one-hot select", row_sel, exp_sel);
        end
        if (!frame_pol) begin
            chk(row_on_lvl == 4'd9 && row_off_lvl == 4'd1, "R5 row codes pol0",
                {row_on_lvl, row_off_lvl}, 8'h91);
            chk(col_on_lvl == 4'd0 && col_off_lvl == 4'd2, "R6 col codes pol0",
                {col_on_lvl, col_off_lvl}, 8'h02);
        end else begin
            chk(row_on_lvl == 4'd0 && row_off_lvl == 4'd8, "R5 row codes pol1",
                {row_on_lvl, row_off_lvl}, 8'h08);
            chk(col_on_lvl == 4'd9 && col_off_lvl == 4'd7, "R6 col codes pol1",
                {col_on_lvl, col_off_lvl}, 8'h97);
        end
    endtask

    task automatic step(input bit t, input bit en);
        tick = t;
        enable = en;
        @(posedge clk);
        if (rst || !en) n = 0;
        else if (t) n++;
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset(input int k);
        rst = 1'b1;
        for (int i = 0; i < k; i++) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        // R7: state right after reset, before any tick
        chk(line_pulse == 1'b0 && frame_pol == 1'b0 && row_idx == 6'd0,
            "R7 reset state", {line_pulse, frame_pol, row_idx}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        enable = 1'b1;
        do_reset(3);
        // R2 R3 R4: continuous ticks through two polarity inversions
        for (int i = 0; i < 1100; i++) step(1'b1, 1'b1);
        // R8: sparse ticks, state holds between them
        for (int i = 0; i < 700; i++) step(i % 3 == 0, 1'b1);
        // R9: disabled with ticks present
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        // R9: restart behaves as after reset
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        // R7: reset in the middle of a frame
        do_reset(2);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule